// File: doc/BRIEF.md
# Programmable RGB Panel Timing Generator

This block produces the scan timing for a parallel RGB display from a single pixel clock. A horizontal counter sweeps each line through four regions in a fixed order: sync pulse, back porch, active pixels, front porch. A vertical counter steps once per line through the same four regions. The active area is the intersection of the horizontal and vertical active regions. Inside it, the block takes exactly one pixel per clock from a first-word-fall-through FIFO and widens it to 24-bit RGB888 before driving it onto the pixel bus.

All region lengths, the polarity of each control output and the source pixel format come from configuration inputs. These values are copied into a shadow set at the first clock after reset and at each frame boundary, so a change made during a frame takes effect only from the next frame. If the FIFO is empty while the scan is in the active area, the block drives black and raises a sticky underrun flag. For downstream logic, the block also provides a one-clock start-of-frame pulse and the raw scan position.

Top module: `rgb_panel_timer`

## Requirements
- R1: A line lasts h_sync+h_back+h_act+h_front clocks and a frame lasts v_sync+v_back+v_act+v_front lines. `h_pos` counts 0 up to the line length minus 1 and then wraps. `v_pos` advances when `h_pos` wraps.
- R2: The horizontal sync is at its asserted level exactly while `h_pos` < h_sync, on every line.
- R3: The vertical sync is at its asserted level exactly while `v_pos` < v_sync, for whole lines.
- R4: The scan is in the active area when h_sync+h_back ≤ `h_pos` < h_sync+h_back+h_act and v_sync+v_back ≤ `v_pos` < v_sync+v_back+v_act. Data enable is asserted only there. `fifo_pop` is high exactly when the scan is in the active area and `fifo_empty` is low. Outside the active area, `pix` is zero.
- R5: Each bit of `cfg_pol` sets the asserted level of one output, with 1 meaning active high. Bit 0 controls hsync, bit 1 controls vsync and bit 2 controls data enable.
- R6: `cfg_fmt` selects how the source pixel is read. With value 0 (or 3), the source is RGB888 on bits 23:0 with red in the top byte. With value 1, the source is RGB666 on bits 17:0 (R 17:12, G 11:6, B 5:0). With value 2, the source is RGB565 on bits 15:0 (R 15:11, G 10:5, B 4:0). Each narrow channel is widened by appending its own top bits, so a 5-bit channel x becomes {x, x[4:2]} and a 6-bit channel y becomes {y, y[5:4]}.
- R7: When `fifo_empty` is high in the active area, `pix` is zero and `underrun` is 1 from the next clock onward. A high `underrun_clr` clears the flag on the next clock, unless a new starvation occurs in the same cycle, in which case the flag stays set.
- R8: The configuration inputs are sampled only at the first clock after reset and at the last clock of a frame. A change in mid-frame has no effect until the next frame starts.
- R9: `sof` is high for exactly one clock per frame, namely the clock where `h_pos` and `v_pos` are both 0.
- R10: While reset is asserted, data enable, `fifo_pop`, `sof`, `underrun` and `pix` are inactive or zero, and the syncs sit at the inactive level given by the live `cfg_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_sync | input | 12 | Horizontal sync width in clocks (≥1) |
| cfg_h_back | input | 12 | Horizontal back porch in clocks |
| cfg_h_act | input | 12 | Active pixels per line (≥1) |
| cfg_h_front | input | 12 | Horizontal front porch in clocks |
| cfg_v_sync | input | 12 | Vertical sync width in lines (≥1) |
| cfg_v_back | input | 12 | Vertical back porch in lines |
| cfg_v_act | input | 12 | Active lines per frame (≥1) |
| cfg_v_front | input | 12 | Vertical front porch in lines |
| cfg_pol | input | 3 | Asserted level per output: bit0 hsync, bit1 vsync, bit2 data enable |
| cfg_fmt | input | 2 | Source pixel format: 0 RGB888, 1 RGB666, 2 RGB565 |
| fifo_data | input | 24 | Head word of the pixel FIFO |
| fifo_empty | input | 1 | FIFO has no pixel |
| fifo_pop | output | 1 | Consume the head pixel this clock |
| underrun_clr | input | 1 | Write-one clear of the underrun flag |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix | output | 24 | RGB888 pixel bus |
| sof | output | 1 | Start-of-frame pulse |
| h_pos | output | 14 | Current clock within the line |
| v_pos | output | 14 | Current line within the frame |
| underrun | output | 1 | Sticky FIFO starvation flag |

## Verification
The position counters drive every output, so a wrong counter value shows up in the same clock as a sync or enable edge at the wrong column. It also shows as an `h_pos`/`v_pos` pair that differs from the bench's own cycle count, and the `sof` pulse then arrives a clock early or late. A shadow configuration that updates at the wrong moment is exposed by a mid-frame change, because the rest of that frame then no longer matches the old geometry. Errors in the underrun flag appear one clock after the starving or clearing cycle. Errors in format widening appear on the same clock as the pop.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;
  localparam int SPAN_W = 12;
  localparam int POS_W  = SPAN_W + 2;
  localparam int PIX_W  = 24;
  localparam int POL_W  = 3;
  localparam int POL_HS = 0;
  localparam int POL_VS = 1;
  localparam int POL_DE = 2;

  typedef logic [SPAN_W-1:0] span_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [PIX_W-1:0]  pix_t;

  typedef enum logic [1:0] {
    FMT_888 = 2'd0,
    FMT_666 = 2'd1,
    FMT_565 = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef struct packed {
    span_t h_sync;
    span_t h_back;
    span_t h_act;
    span_t h_front;
    span_t v_sync;
    span_t v_back;
    span_t v_act;
    span_t v_front;
  } geom_t;

  typedef struct packed {
    geom_t            geom;
    logic [POL_W-1:0] pol;
    fmt_e             fmt;
  } timing_t;

  function automatic pos_t span_add(span_t a, span_t b);
    return pos_t'(a) + pos_t'(b);
  endfunction

  function automatic pos_t line_len(geom_t g);
    return span_add(g.h_sync, g.h_back) + span_add(g.h_act, g.h_front);
  endfunction

  function automatic pos_t frame_len(geom_t g);
    return span_add(g.v_sync, g.v_back) + span_add(g.v_act, g.v_front);
  endfunction

  // true when pos lies in [lead, lead+len)
  function automatic logic in_window(pos_t pos, pos_t lead, span_t len);
    return (pos >= lead) && (pos < lead + pos_t'(len));
  endfunction

  function automatic pix_t widen(fmt_e f, pix_t d);
    case (f)
      FMT_666: return {d[17:12], d[17:16], d[11:6], d[11:10], d[5:0], d[5:4]};
      FMT_565: return {d[15:11], d[15:13], d[10:5], d[10:9], d[4:0], d[4:2]};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/rgbt_shadow.sv
module rgbt_shadow import rgbt_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  timing_t cfg_in,
  input  logic    frame_end,
  output timing_t cfg_q,
  output logic    armed
);
  logic take;
  assign take = !armed || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      armed <= 1'b0;
    end else if (take) begin
      cfg_q <= cfg_in;
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/rgbt_scan.sv
module rgbt_scan import rgbt_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  armed,
  input  geom_t geom,
  output pos_t  h_pos,
  output pos_t  v_pos,
  output logic  line_end,
  output logic  frame_end,
  output logic  hs_on,
  output logic  vs_on,
  output logic  in_active
);
  pos_t h_last, v_last, h_lead, v_lead;

  assign h_last    = line_len(geom) - pos_t'(1);
  assign v_last    = frame_len(geom) - pos_t'(1);
  assign h_lead    = span_add(geom.h_sync, geom.h_back);
  assign v_lead    = span_add(geom.v_sync, geom.v_back);
  assign line_end  = armed && (h_pos == h_last);
  assign frame_end = line_end && (v_pos == v_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (armed) begin
      if (line_end) begin
        h_pos <= '0;
        v_pos <= frame_end ? '0 : v_pos + pos_t'(1);
      end else begin
        h_pos <= h_pos + pos_t'(1);
      end
    end
  end

  assign hs_on     = armed && (h_pos < pos_t'(geom.h_sync));
  assign vs_on     = armed && (v_pos < pos_t'(geom.v_sync));
  assign in_active = armed && in_window(h_pos, h_lead, geom.h_act)
                           && in_window(v_pos, v_lead, geom.v_act);
endmodule

// File: rtl/rgbt_pixel.sv
module rgbt_pixel import rgbt_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic in_active,
  input  fmt_e fmt,
  input  pix_t fifo_data,
  input  logic fifo_empty,
  input  logic underrun_clr,
  output logic fifo_pop,
  output pix_t pix,
  output logic starve,
  output logic underrun
);
  assign starve   = in_active && fifo_empty;
  assign fifo_pop = in_active && !fifo_empty;
  assign pix      = fifo_pop ? widen(fmt, fifo_data) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            underrun <= 1'b0;
    else if (starve)       underrun <= 1'b1;
    else if (underrun_clr) underrun <= 1'b0;
  end
endmodule

// File: rtl/rgb_panel_timer.sv
module rgb_panel_timer import rgbt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPAN_W-1:0] cfg_h_sync,
  input  logic [SPAN_W-1:0] cfg_h_back,
  input  logic [SPAN_W-1:0] cfg_h_act,
  input  logic [SPAN_W-1:0] cfg_h_front,
  input  logic [SPAN_W-1:0] cfg_v_sync,
  input  logic [SPAN_W-1:0] cfg_v_back,
  input  logic [SPAN_W-1:0] cfg_v_act,
  input  logic [SPAN_W-1:0] cfg_v_front,
  input  logic [POL_W-1:0]  cfg_pol,
  input  logic [1:0]        cfg_fmt,
  input  logic [PIX_W-1:0]  fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic              underrun_clr,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PIX_W-1:0]  pix,
  output logic              sof,
  output logic [POS_W-1:0]  h_pos,
  output logic [POS_W-1:0]  v_pos,
  output logic              underrun
);
  timing_t          cfg_live, cfg_q;
  logic             armed, line_end, frame_end;
  logic             hs_on, vs_on, in_active, starve;
  logic [POL_W-1:0] pol_eff;

  assign cfg_live = '{
    geom: '{h_sync: cfg_h_sync, h_back: cfg_h_back, h_act: cfg_h_act, h_front: cfg_h_front,
            v_sync: cfg_v_sync, v_back: cfg_v_back, v_act: cfg_v_act, v_front: cfg_v_front},
    pol:  cfg_pol,
    fmt:  fmt_e'(cfg_fmt)
  };

  rgbt_shadow u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_in    (cfg_live),
    .frame_end (frame_end),
    .cfg_q     (cfg_q),
    .armed     (armed)
  );

  rgbt_scan u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .geom      (cfg_q.geom),
    .h_pos     (h_pos),
    .v_pos     (v_pos),
    .line_end  (line_end),
    .frame_end (frame_end),
    .hs_on     (hs_on),
    .vs_on     (vs_on),
    .in_active (in_active)
  );

  rgbt_pixel u_pixel (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_active    (in_active),
    .fmt          (cfg_q.fmt),
    .fifo_data    (fifo_data),
    .fifo_empty   (fifo_empty),
    .underrun_clr (underrun_clr),
    .fifo_pop     (fifo_pop),
    .pix          (pix),
    .starve       (starve),
    .underrun     (underrun)
  );

  // before the first shadow load the live polarity defines the idle level
  assign pol_eff = armed ? cfg_q.pol : cfg_pol;
  assign hsync   = pol_eff[POL_HS] ? hs_on     : !hs_on;
  assign vsync   = pol_eff[POL_VS] ? vs_on     : !vs_on;
  assign de      = pol_eff[POL_DE] ? in_active : !in_active;
  assign sof     = armed && (h_pos == '0) && (v_pos == '0);
endmodule

// File: rtl/rgbt_checker.sv
module rgbt_checker import rgbt_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic             line_end,
  input logic             frame_end,
  input logic             in_active,
  input logic             starve,
  input logic             fifo_empty,
  input logic             fifo_pop,
  input logic             underrun,
  input logic             underrun_clr,
  input logic             sof,
  input logic             de,
  input logic [POL_W-1:0] pol_eff,
  input pos_t             h_pos,
  input pos_t             v_pos,
  input pix_t             pix,
  input timing_t          cfg_q
);
  p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> h_pos == '0);

  p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !line_end) |=> h_pos == pos_t'($past(h_pos) + pos_t'(1)));

  p_pop_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (in_active && !fifo_empty));

  p_de_area_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && de == pol_eff[POL_DE]) |-> in_active);

  p_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
    starve |-> pix == '0);

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> underrun);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !frame_end) |=> $stable(cfg_q));

  p_sof_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (h_pos == '0 && v_pos == '0));
endmodule

bind rgb_panel_timer rgbt_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .armed        (armed),
  .line_end     (line_end),
  .frame_end    (frame_end),
  .in_active    (in_active),
  .starve       (starve),
  .fifo_empty   (fifo_empty),
  .fifo_pop     (fifo_pop),
  .underrun     (underrun),
  .underrun_clr (underrun_clr),
  .sof          (sof),
  .de           (de),
  .pol_eff      (pol_eff),
  .h_pos        (h_pos),
  .v_pos        (v_pos),
  .pix          (pix),
  .cfg_q        (cfg_q)
);

// File: tb/tb_rgb_panel_timer.sv
module tb_rgb_panel_timer;
  typedef struct {
    int hs, hb, ha, hf, vs, vb, va, vf;
    int pol, fmt;
  } tcfg_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] c_hs, c_hb, c_ha, c_hf, c_vs, c_vb, c_va, c_vf;
  logic [2:0]  c_pol;
  logic [1:0]  c_fmt;
  logic [23:0] fifo_data = '0;
  logic        fifo_empty = 1'b1;
  logic        fifo_pop;
  logic        underrun_clr = 1'b0;
  logic        hsync, vsync, de, sof, underrun;
  logic [23:0] pix;
  logic [13:0] h_pos, v_pos;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  bit  exp_und = 0;

  always #10 clk = ~clk;

  rgb_panel_timer dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_sync(c_hs), .cfg_h_back(c_hb), .cfg_h_act(c_ha), .cfg_h_front(c_hf),
    .cfg_v_sync(c_vs), .cfg_v_back(c_vb), .cfg_v_act(c_va), .cfg_v_front(c_vf),
    .cfg_pol(c_pol), .cfg_fmt(c_fmt),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .underrun_clr(underrun_clr),
    .hsync(hsync), .vsync(vsync), .de(de), .pix(pix), .sof(sof),
    .h_pos(h_pos), .v_pos(v_pos), .underrun(underrun)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic apply(tcfg_t c);
    c_hs = 12'(c.hs); c_hb = 12'(c.hb); c_ha = 12'(c.ha); c_hf = 12'(c.hf);
    c_vs = 12'(c.vs); c_vb = 12'(c.vb); c_va = 12'(c.va); c_vf = 12'(c.vf);
    c_pol = 3'(c.pol); c_fmt = 2'(c.fmt);
  endtask

  function automatic int grow(int v, int bits);
    return (v << (8 - bits)) | (v >> (2 * bits - 8));
  endfunction

  function automatic logic [23:0] ref_pix(int fmt, logic [23:0] d);
    int w = int'(d);
    int r, g, b;
    if (fmt == 1) begin
      r = grow((w >> 12) % 64, 6); g = grow((w >> 6) % 64, 6); b = grow(w % 64, 6);
    end else if (fmt == 2) begin
      r = grow((w >> 11) % 32, 5); g = grow((w >> 5) % 64, 6); b = grow(w % 32, 5);
    end else begin
      return d;
    end
    return 24'((r << 16) + (g << 8) + b);
  endfunction

  function automatic tcfg_t rand_cfg();
    tcfg_t c;
    c.hs = 1 + $urandom % 4; c.hb = $urandom % 5; c.ha = 1 + $urandom % 8; c.hf = $urandom % 4;
    c.vs = 1 + $urandom % 3; c.vb = $urandom % 4; c.va = 1 + $urandom % 5; c.vf = $urandom % 3;
    c.pol = $urandom % 8; c.fmt = $urandom % 4;
    return c;
  endfunction

  // one full frame checked cycle by cycle; nxt is driven from mid-frame on
  task automatic run_frame(tcfg_t c, tcfg_t nxt, bit directed);
    int ht = c.hs + c.hb + c.ha + c.hf;
    int vt = c.vs + c.vb + c.va + c.vf;
    int half = (ht * vt) / 2;
    for (int i = 0; i < ht * vt; i++) begin
      int  h = i % ht;
      int  v = i / ht;
      bit  hs_on = (h < c.hs);
      bit  vs_on = (v < c.vs);
      bit  act = (h >= c.hs + c.hb) && (h < c.hs + c.hb + c.ha) &&
                 (v >= c.vs + c.vb) && (v < c.vs + c.vb + c.va);
      logic [23:0] d;
      bit  emp, clr;
      @(negedge clk);
      if (i == half) apply(nxt);
      d   = 24'($urandom);
      emp = ($urandom % 8 == 0);
      clr = ($urandom % 16 == 0);
      if (directed && h == c.hs + c.hb && v == c.vs + c.vb) begin
        emp = 1; clr = 1;  // set must win over clear
      end
      fifo_data = d; fifo_empty = emp; underrun_clr = clr;
      #1;
      chk("R1 h_pos", 32'(h_pos), 32'(h));
      chk("R1 v_pos", 32'(v_pos), 32'(v));
      chk("R9 sof", 32'(sof), 32'(i == 0));
      chk("R2 R5 hsync", 32'(hsync), 32'(c.pol[0] ? hs_on : !hs_on));
      chk("R3 R5 vsync", 32'(vsync), 32'(c.pol[1] ? vs_on : !vs_on));
      chk("R4 R5 de", 32'(de), 32'(c.pol[2] ? act : !act));
      chk("R4 fifo_pop", 32'(fifo_pop), 32'(act && !emp));
      if (act && !emp)  chk("R6 pix", 32'(pix), 32'(ref_pix(c.fmt, d)));
      else if (act)     chk("R7 pix black", 32'(pix), 32'(0));
      else              chk("R4 pix idle", 32'(pix), 32'(0));
      chk("R7 underrun", 32'(underrun), 32'(exp_und));
      if (i > half) chk("R8 old geometry", 32'({hsync, vsync, de}),
                        32'({c.pol[0] ? hs_on : !hs_on, c.pol[1] ? vs_on : !vs_on,
                             c.pol[2] ? act : !act}));
      if (act && emp) exp_und = 1;
      else if (clr)   exp_und = 0;
    end
  endtask

  initial begin
    tcfg_t a, b, cur, nx;
    void'($urandom(32'd20240517));
    a = '{hs:2, hb:3, ha:6, hf:1, vs:1, vb:2, va:4, vf:1, pol:4, fmt:2};
    b = '{hs:1, hb:0, ha:3, hf:0, vs:2, vb:0, va:2, vf:0, pol:3, fmt:1};
    apply(a);
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state with de active high and syncs active low
    chk("R10 hsync", 32'(hsync), 32'(1));
    chk("R10 vsync", 32'(vsync), 32'(1));
    chk("R10 de", 32'(de), 32'(0));
    chk("R10 pop", 32'(fifo_pop), 32'(0));
    chk("R10 sof", 32'(sof), 32'(0));
    chk("R10 underrun", 32'(underrun), 32'(0));
    chk("R10 pix", 32'(pix), 32'(0));
    rst_n = 1'b1;
    run_frame(a, a, 1);
    run_frame(a, b, 0);
    cur = b;
    for (int k = 0; k < 8; k++) begin
      nx = rand_cfg();
      run_frame(cur, nx, k == 2);
      cur = nx;
    end
    nx = cur; nx.fmt = 0; nx.pol = 7;
    run_frame(cur, nx, 0);
    run_frame(nx, nx, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule